// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block fetches a single instruction at a given program counter. It works in 16-bit granules. First it checks alignment. It then translates the PC, reads the halfword at the physical address it gets back, and looks at the two low bits of that halfword. A halfword whose low bits are not `11` is a complete compressed instruction, and the fetch ends there. Any other halfword starts a full-width instruction. In that case the unit translates PC+2 as an independent access and reads a second halfword. Because each granule is translated and read on its own, a fault in either one is reported with that granule's exact address.

The fetch request uses valid/ready. `fetch_ready` is high only while the unit is idle, so it is the only back-pressure on the requester. `fetch_pc` and `fetch_rvc_en` are sampled in the cycle where valid and ready are both high. The translation port and the memory port each use a held request with a one-cycle response strobe. The unit keeps its request valid and its address stable until the responder returns a response, which may come in the same cycle or after any number of wait cycles. A response strobe that arrives with no request outstanding is ignored. The outcome is a one-cycle `res_valid` pulse with a result kind. The result side cannot be stalled, so the consumer must take the pulse when it appears.

Top module: `ifu_fetch`

## Requirements
- R1: When a fetch is accepted with `fetch_pc[0]`=1, or with `fetch_pc[1]`=1 and `fetch_rvc_en`=0, the next cycle gives `res_valid`=1, `res_kind`=3 (error), `res_cause`=0 (misaligned) and `res_addr`=PC. No translation request is issued.
- R2: If the first halfword has bits [1:0] != 2'b11, the result is `res_kind`=1 (compressed) with `res_insn`={16'h0, halfword}. Exactly one translation and one memory access are made.
- R3: Otherwise PC+2 is translated separately and a second halfword is read. The result is `res_kind`=2 (base) with `res_insn`={upper halfword, lower halfword}.
- R4: A translation response with `tr_rsp_fault`=1 ends the fetch with `res_kind`=3. `res_cause` carries `tr_rsp_cause`, and `res_addr` is PC for the first granule or PC+2 for the second.
- R5: A memory response with `mem_rsp_err`=1 ends the fetch with `res_kind`=3 and `res_cause`=1 (access fault). `res_addr` is PC for the first granule or PC+2 for the second.
- R6: Each memory read address equals the physical address returned by the translation response just before it.
- R7: A translation or memory request stays valid, with its address unchanged, until the matching response strobe arrives.
- R8: `fetch_ready` is high only when idle, with no request outstanding. Changes to `fetch_pc` after acceptance do not affect the fetch in flight.
- R9: `res_valid` is a single-cycle pulse for each fetch.
- R10: After reset, `fetch_ready`=1 and `res_valid`, `tr_req_valid` and `mem_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Unit idle, request can be taken |
| fetch_pc | input | XLEN | Program counter to fetch |
| fetch_rvc_en | input | 1 | Compressed instructions enabled |
| tr_req_valid | output | 1 | Translation request outstanding |
| tr_req_vaddr | output | XLEN | Virtual address to translate |
| tr_rsp_valid | input | 1 | Translation response strobe |
| tr_rsp_fault | input | 1 | Translation failed |
| tr_rsp_cause | input | CAUSE_W | Cause code of translation failure |
| tr_rsp_paddr | input | XLEN | Translated physical address |
| mem_req_valid | output | 1 | Halfword read request outstanding |
| mem_req_paddr | output | XLEN | Physical address of halfword |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_err | input | 1 | Memory read error |
| mem_rsp_data | input | 16 | Halfword read data |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 1 compressed, 2 base, 3 error |
| res_insn | output | 32 | Instruction bits |
| res_cause | output | CAUSE_W | Exception cause when error |
| res_addr | output | XLEN | Faulting address when error |

## Verification
The hardest case to reach is a fault on the upper granule. It needs a full-width first halfword that translates and reads cleanly, followed by a failure on PC+2 alone. The bench's translation stub therefore faults on one programmable virtual address, and its memory stub errors on one programmable physical address. Each is aimed at the translated PC+2 while the first halfword carries low bits `11`. Both stubs also insert a programmable number of wait cycles, which keeps each request outstanding while the bench moves `fetch_pc` underneath it.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_C    = 2'd1,
    KIND_BASE = 2'd2,
    KIND_ERR  = 2'd3
  } res_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XL_LO,
    ST_RD_LO,
    ST_XL_HI,
    ST_RD_HI
  } fetch_st_e;

  localparam int CODE_MISALIGN = 0;
  localparam int CODE_ACCESS   = 1;
  localparam int GRANULE_BYTES = 2;
endpackage

// File: rtl/ifu_prechk.sv
module ifu_prechk #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic            rvc_en,
  input  logic [15:0]     half,
  output logic            misaligned,
  output logic            is_rvc
);
  always_comb begin
    misaligned = pc[0] | (pc[1] & ~rvc_en);
    is_rvc     = (half[1:0] != 2'b11);
  end
endmodule

// File: rtl/ifu_result_reg.sv
module ifu_result_reg #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         kind_d,
  input  logic [31:0]        insn_d,
  input  logic [CAUSE_W-1:0] cause_d,
  input  logic [XLEN-1:0]    addr_d,
  output logic               valid_q,
  output logic [1:0]         kind_q,
  output logic [31:0]        insn_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= '0;
      insn_q  <= '0;
      cause_q <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        kind_q  <= kind_d;
        insn_q  <= insn_d;
        cause_q <= cause_d;
        addr_q  <= addr_d;
      end
    end
  end
endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [XLEN-1:0]    fetch_pc,
  input  logic               fetch_rvc_en,
  output logic               tr_req_valid,
  output logic [XLEN-1:0]    tr_req_vaddr,
  input  logic               tr_rsp_valid,
  input  logic               tr_rsp_fault,
  input  logic [CAUSE_W-1:0] tr_rsp_cause,
  input  logic [XLEN-1:0]    tr_rsp_paddr,
  output logic               mem_req_valid,
  output logic [XLEN-1:0]    mem_req_paddr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [15:0]        mem_rsp_data,
  output logic               res_valid,
  output logic [1:0]         res_kind,
  output logic [31:0]        res_insn,
  output logic [CAUSE_W-1:0] res_cause,
  output logic [XLEN-1:0]    res_addr
);
  import ifu_pkg::*;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = CAUSE_W'(CODE_MISALIGN);
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = CAUSE_W'(CODE_ACCESS);
  localparam logic [XLEN-1:0]    HI_OFFSET      = XLEN'(GRANULE_BYTES);

  fetch_st_e          state_q, state_d;
  logic [XLEN-1:0]    pc_q;
  logic [XLEN-1:0]    paddr_q;
  logic [15:0]        lo_q;
  logic               hi_phase;
  logic [XLEN-1:0]    gran_addr;
  logic               misaligned, is_rvc;

  logic               ld;
  logic [1:0]         kind_d;
  logic [31:0]        insn_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [XLEN-1:0]    addr_d;

  ifu_prechk #(.XLEN(XLEN)) u_prechk (
    .pc         (fetch_pc),
    .rvc_en     (fetch_rvc_en),
    .half       (mem_rsp_data),
    .misaligned (misaligned),
    .is_rvc     (is_rvc)
  );

  assign hi_phase      = (state_q == ST_XL_HI) || (state_q == ST_RD_HI);
  assign gran_addr     = hi_phase ? (pc_q + HI_OFFSET) : pc_q;
  assign fetch_ready   = (state_q == ST_IDLE);
  assign tr_req_valid  = (state_q == ST_XL_LO) || (state_q == ST_XL_HI);
  assign tr_req_vaddr  = gran_addr;
  assign mem_req_valid = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign mem_req_paddr = paddr_q;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    kind_d  = KIND_NONE;
    insn_d  = '0;
    cause_d = '0;
    addr_d  = gran_addr;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_valid) begin
          if (misaligned) begin
            ld      = 1'b1;
            kind_d  = KIND_ERR;
            cause_d = CAUSE_MISALIGN;
            addr_d  = fetch_pc;
          end else begin
            state_d = ST_XL_LO;
          end
        end
      end
      ST_XL_LO, ST_XL_HI: begin
        if (tr_rsp_valid) begin
          if (tr_rsp_fault) begin
            ld      = 1'b1;
            kind_d  = KIND_ERR;
            cause_d = tr_rsp_cause;
            state_d = ST_IDLE;
          end else begin
            state_d = hi_phase ? ST_RD_HI : ST_RD_LO;
          end
        end
      end
      ST_RD_LO, ST_RD_HI: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          ld      = 1'b1;
          if (mem_rsp_err) begin
            kind_d  = KIND_ERR;
            cause_d = CAUSE_ACCESS;
          end else if (hi_phase) begin
            kind_d = KIND_BASE;
            insn_d = {mem_rsp_data, lo_q};
          end else if (is_rvc) begin
            kind_d = KIND_C;
            insn_d = {16'h0000, mem_rsp_data};
          end else begin
            ld      = 1'b0;
            state_d = ST_XL_HI;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      paddr_q <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (fetch_ready && fetch_valid) pc_q <= fetch_pc;
      if (tr_req_valid && tr_rsp_valid) paddr_q <= tr_rsp_paddr;
      if (state_q == ST_RD_LO && mem_rsp_valid) lo_q <= mem_rsp_data;
    end
  end

  ifu_result_reg #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .kind_d  (kind_d),
    .insn_d  (insn_d),
    .cause_d (cause_d),
    .addr_d  (addr_d),
    .valid_q (res_valid),
    .kind_q  (res_kind),
    .insn_q  (res_insn),
    .cause_q (res_cause),
    .addr_q  (res_addr)
  );
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_valid,
  input logic               fetch_ready,
  input logic [XLEN-1:0]    fetch_pc,
  input logic               fetch_rvc_en,
  input logic               tr_req_valid,
  input logic [XLEN-1:0]    tr_req_vaddr,
  input logic               tr_rsp_valid,
  input logic               tr_rsp_fault,
  input logic [CAUSE_W-1:0] tr_rsp_cause,
  input logic [XLEN-1:0]    tr_rsp_paddr,
  input logic               mem_req_valid,
  input logic [XLEN-1:0]    mem_req_paddr,
  input logic               mem_rsp_valid,
  input logic               mem_rsp_err,
  input logic [15:0]        mem_rsp_data,
  input logic               res_valid,
  input logic [1:0]         res_kind,
  input logic [31:0]        res_insn,
  input logic [CAUSE_W-1:0] res_cause,
  input logic [XLEN-1:0]    res_addr
);
  AST_TR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_req_valid && !tr_rsp_valid) |=> (tr_req_valid && $stable(tr_req_vaddr))); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_paddr))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> (!tr_req_valid && !mem_req_valid)); // R8
  AST_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && fetch_pc[0]) |=>
      (res_valid && res_kind == 2'd3 && res_addr == $past(fetch_pc) && !tr_req_valid)); // R1
  AST_C_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd1) |-> (res_insn[1:0] != 2'b11 && res_insn[31:16] == 16'h0)); // R2
  AST_BASE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2) |-> (res_insn[1:0] == 2'b11)); // R3
  AST_MEM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> (mem_req_paddr == $past(tr_rsp_paddr))); // R6
endmodule

bind ifu_fetch ifu_fetch_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/ifu_fetch_tb.sv
module ifu_fetch_tb;
  localparam int XLEN = 32;
  localparam int CW   = 4;
  localparam logic [XLEN-1:0] XOR_MAP = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            fetch_valid = 1'b0;
  logic            fetch_ready;
  logic [XLEN-1:0] fetch_pc = '0;
  logic            fetch_rvc_en = 1'b1;
  logic            tr_req_valid;
  logic [XLEN-1:0] tr_req_vaddr;
  logic            tr_rsp_valid = 1'b0;
  logic            tr_rsp_fault = 1'b0;
  logic [CW-1:0]   tr_rsp_cause = '0;
  logic [XLEN-1:0] tr_rsp_paddr = '0;
  logic            mem_req_valid;
  logic [XLEN-1:0] mem_req_paddr;
  logic            mem_rsp_valid = 1'b0;
  logic            mem_rsp_err = 1'b0;
  logic [15:0]     mem_rsp_data = '0;
  logic            res_valid;
  logic [1:0]      res_kind;
  logic [31:0]     res_insn;
  logic [CW-1:0]   res_cause;
  logic [XLEN-1:0] res_addr;

  ifu_fetch #(.XLEN(XLEN), .CAUSE_W(CW)) u_dut (.*);

  int checks = 0;
  int fails  = 0;

  // Stub configuration
  int              dly = 0;
  logic [XLEN-1:0] lo_paddr = '0;
  logic [15:0]     lo_data = '0, hi_data = '0;
  logic            xl_fault_en = 1'b0;
  logic [XLEN-1:0] xl_fault_va = '0;
  logic [CW-1:0]   xl_fault_cause = '0;
  logic            mem_err_en = 1'b0;
  logic [XLEN-1:0] mem_err_pa = '0;

  // Stub logs
  int              tr_n = 0, mem_n = 0;
  logic [XLEN-1:0] last_va = '0, last_pa = '0;
  int              tr_wait = 0, mem_wait = 0;

  always @(negedge clk) begin
    tr_rsp_valid = 1'b0;
    tr_rsp_fault = 1'b0;
    if (tr_req_valid && !tr_rsp_valid && rst_n) begin
      if (tr_wait >= dly) begin
        tr_wait = 0;
        tr_rsp_valid = 1'b1;
        tr_rsp_fault = xl_fault_en && (tr_req_vaddr == xl_fault_va);
        tr_rsp_cause = xl_fault_cause;
        tr_rsp_paddr = tr_req_vaddr ^ XOR_MAP;
        last_va = tr_req_vaddr;
        tr_n++;
      end else tr_wait++;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err = 1'b0;
    if (mem_req_valid && !mem_rsp_valid && rst_n) begin
      if (mem_wait >= dly) begin
        mem_wait = 0;
        mem_rsp_valid = 1'b1;
        mem_rsp_err = mem_err_en && (mem_req_paddr == mem_err_pa);
        mem_rsp_data = (mem_req_paddr == lo_paddr) ? lo_data : hi_data;
        last_pa = mem_req_paddr;
        mem_n++;
      end else mem_wait++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [1:0]      g_kind;
  logic [31:0]     g_insn;
  logic [CW-1:0]   g_cause;
  logic [XLEN-1:0] g_addr;
  int              g_tr, g_mem;
  logic            g_busy_ok;

  task automatic do_fetch(input logic [XLEN-1:0] pc, input logic en);
    int t0, m0, n;
    t0 = tr_n; m0 = mem_n;
    lo_paddr = pc ^ XOR_MAP;
    g_busy_ok = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc; fetch_rvc_en = en;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_pc = 32'hDEAD_BEE0; fetch_rvc_en = 1'b0;
    n = 0;
    while (!res_valid && n < 200) begin
      if (fetch_ready) g_busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    g_kind = res_kind; g_insn = res_insn; g_cause = res_cause; g_addr = res_addr;
    chk(res_valid, "R9 result arrives", {31'd0, res_valid}, 32'd1);
    @(negedge clk);
    chk(!res_valid, "R9 single-cycle pulse", {31'd0, res_valid}, 32'd0);
    g_tr = tr_n - t0; g_mem = mem_n - m0;
  endtask

  task automatic t_reset();
    chk(fetch_ready, "R10 ready after reset", {31'd0, fetch_ready}, 32'd1);
    chk(!res_valid && !tr_req_valid && !mem_req_valid, "R10 quiet after reset",
        {29'd0, res_valid, tr_req_valid, mem_req_valid}, 32'd0);
  endtask

  task automatic t_misalign();
    do_fetch(32'h0000_1001, 1'b1);
    chk(g_kind == 2'd3 && g_cause == 4'd0, "R1 odd pc kind/cause", {26'd0, g_kind, g_cause}, {26'd0, 2'd3, 4'd0});
    chk(g_addr == 32'h0000_1001 && g_tr == 0, "R1 odd pc addr, no translation", g_addr, 32'h0000_1001);
    do_fetch(32'h0000_2002, 1'b0);
    chk(g_kind == 2'd3 && g_cause == 4'd0 && g_addr == 32'h0000_2002, "R1 pc[1] with compressed off",
        g_addr, 32'h0000_2002);
  endtask

  task automatic t_compressed(input logic [15:0] h, input int d);
    dly = d; lo_data = h; hi_data = 16'hFFFF;
    do_fetch(32'h0000_3002, 1'b1);
    chk(g_kind == 2'd1 && g_insn == {16'h0, h}, "R2 compressed result", g_insn, {16'h0, h});
    chk(g_tr == 1 && g_mem == 1, "R2 single access", g_tr * 16 + g_mem, 32'h11);
    chk(last_pa == (32'h0000_3002 ^ XOR_MAP), "R6 translated address used", last_pa, 32'h0000_3002 ^ XOR_MAP);
  endtask

  task automatic t_base(input int d);
    dly = d; lo_data = 16'h0513; hi_data = 16'h1234;
    do_fetch(32'h0000_4000, 1'b0);
    chk(g_kind == 2'd2 && g_insn == 32'h1234_0513, "R3 base instruction", g_insn, 32'h1234_0513);
    chk(g_tr == 2 && g_mem == 2, "R3 two granules", g_tr * 16 + g_mem, 32'h22);
    chk(last_va == 32'h0000_4002, "R8 latched pc used for upper granule", last_va, 32'h0000_4002);
    chk(last_pa == (32'h0000_4002 ^ XOR_MAP), "R6 upper read at translated pc+2", last_pa, 32'h0000_4002 ^ XOR_MAP);
    chk(g_busy_ok, "R8 ready low while busy", {31'd0, g_busy_ok}, 32'd1);
  endtask

  task automatic t_xl_fault();
    dly = 1; lo_data = 16'h0003; hi_data = 16'h0000;
    xl_fault_en = 1'b1; xl_fault_va = 32'h0000_5000; xl_fault_cause = 4'd12;
    do_fetch(32'h0000_5000, 1'b1);
    chk(g_kind == 2'd3 && g_cause == 4'd12 && g_addr == 32'h0000_5000 && g_mem == 0,
        "R4 lower translation fault", g_addr, 32'h0000_5000);
    xl_fault_va = 32'h0000_5ffe; xl_fault_cause = 4'd13;
    do_fetch(32'h0000_5ffc, 1'b1);
    chk(g_kind == 2'd3 && g_cause == 4'd13, "R4 upper translation cause", {28'd0, g_cause}, 32'd13);
    chk(g_addr == 32'h0000_5ffe && g_mem == 1, "R4 upper fault at pc+2", g_addr, 32'h0000_5ffe);
    xl_fault_en = 1'b0;
  endtask

  task automatic t_mem_err();
    dly = 0; lo_data = 16'h0007; hi_data = 16'h0000;
    mem_err_en = 1'b1; mem_err_pa = 32'h0000_6000 ^ XOR_MAP;
    do_fetch(32'h0000_6000, 1'b1);
    chk(g_kind == 2'd3 && g_cause == 4'd1 && g_addr == 32'h0000_6000, "R5 lower read error", g_addr, 32'h0000_6000);
    mem_err_pa = 32'h0000_6012 ^ XOR_MAP;
    do_fetch(32'h0000_6010, 1'b1);
    chk(g_kind == 2'd3 && g_cause == 4'd1 && g_addr == 32'h0000_6012, "R5 upper read error at pc+2",
        g_addr, 32'h0000_6012);
    mem_err_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_misalign();
    t_compressed(16'h4501, 0);
    t_compressed(16'h8082, 2);
    t_compressed(16'h0000, 1);
    t_base(0);
    t_base(3);
    t_xl_fault();
    t_mem_err();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule